// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block produces the frame, bit and channel timing for a time-division multiplexed serial stream converter. It runs on a 16.384 MHz master clock. A master counter advances once per master clock and wraps after 2048 counts, which is one 125 us frame. An active-low external frame pulse can resynchronise the counter. The pulse is looked at only on falling edges of a 4.096 MHz clock that is phase-locked to the master clock. That slower clock enters as a level sampled by the master clock.

From the counter the block derives three things. The first is a bit strobe and a channel strobe for either the 2.048 Mbit/s or the 4.096 Mbit/s stream rate. The second is the bit index within the current channel and the channel number. The third is a one-clock, active-low early frame pulse for a downstream connection memory. That pulse is issued a fixed number of master clocks ahead of the frame boundary.

A delay-select input moves the counter reset one master clock later. Every derived output then shifts by one clock relative to the input frame boundary. The lead of the early pulse changes with the delay setting.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `frame_cnt` is 0, `cmfp_n` is 1, and `bit_stb`, `chan_stb`, `bit_idx` and `chan_idx` are 0.
- R2: If no frame boundary is detected, `frame_cnt` increases by one every master clock and wraps from 2047 to 0.
- R3: `fp_n` is sampled only on a falling edge of `c4_in`. A falling edge is a clock where `c4_in` is 0 after being 1 in the previous clock. A low level on `fp_n` that has gone before such an edge has no effect on `frame_cnt`.
- R4: A frame boundary is a falling edge of `c4_in` where `fp_n` is 0 and where `fp_n` was 1 at the previous falling edge. With `dly_sel`=0, `frame_cnt` reads 0 right after the master clock edge on which the boundary is detected.
- R5: With `dly_sel`=1, `frame_cnt` still advances normally on the boundary edge and reads 0 one master clock later.
- R6: A frame pulse held low across several `c4_in` falling edges resynchronises the counter only once.
- R7: With `dly_sel`=0, `cmfp_n` is low for exactly one master clock. That clock is the one in which `frame_cnt` reads 1977, which is 71 clocks before the counter reads 0 at the frame boundary.
- R8: With `dly_sel`=1, `cmfp_n` is low for exactly one master clock. That clock is the one in which `frame_cnt` reads 1979, which is 69 clocks before the counter reads 0. The frame boundary itself falls 68 clocks after the pulse.
- R9: With `rate_sel`=0 (2.048 Mbit/s), the following hold in every clock after reset:
  - `bit_stb` is 1 exactly when `frame_cnt` mod 8 is 0.
  - `chan_stb` is 1 exactly when `frame_cnt` mod 64 is 0.
  - `bit_idx` equals (`frame_cnt`/8) mod 8.
  - `chan_idx` equals `frame_cnt`/64.
- R10: With `rate_sel`=1 (4.096 Mbit/s), the following hold in every clock after reset:
  - `bit_stb` is 1 exactly when `frame_cnt` mod 4 is 0.
  - `chan_stb` is 1 exactly when `frame_cnt` mod 32 is 0.
  - `bit_idx` equals (`frame_cnt`/4) mod 8.
  - `chan_idx` equals `frame_cnt`/32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| c4_in | input | 1 | 4.096 MHz clock level, phase-locked to `clk` |
| fp_n | input | 1 | Active-low external frame pulse |
| dly_sel | input | 1 | 0: counter resets on the boundary; 1: counter resets one clock later |
| rate_sel | input | 1 | 0: 2.048 Mbit/s timing; 1: 4.096 Mbit/s timing |
| frame_cnt | output | 11 | Master counter value |
| bit_stb | output | 1 | One-clock strobe at the start of each bit |
| chan_stb | output | 1 | One-clock strobe at the start of each channel |
| bit_idx | output | 3 | Bit index within the current channel |
| chan_idx | output | 6 | Channel number within the frame |
| cmfp_n | output | 1 | Active-low early frame pulse for the connection memory |

## Verification
The bench first checks that a frame pulse asserted and released between falling edges of the 4.096 MHz clock leaves the counter alone. A design that sampled on every master clock would jump to zero there. It then holds the pulse low over several slow-clock edges, which catches a level-triggered design that keeps reloading zero. Both delay settings are covered: a design that applies the delay to the wrong branch shows a counter that reads zero one clock early or late. The early pulse is timed from the boundary to its falling clock and on to the next counter zero, and its width is checked, so a wrong lead constant, an off-by-one target or a stretched pulse is reported. The strobes and indices are compared against the counter over full frames at both rates, which exposes a wrong shift amount or a swapped rate decode.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

  // Serial stream rate selection
  typedef enum logic {
    RATE_2M = 1'b0,
    RATE_4M = 1'b1
  } rate_e;

  // Counter reset placement relative to the sampled frame boundary
  typedef enum logic {
    RST_ON_EDGE = 1'b0,
    RST_LATE    = 1'b1
  } dly_e;

endpackage

// File: rtl/tfg_fp_sampler.sv
module tfg_fp_sampler (
  input  logic clk,
  input  logic rst,
  input  logic c4_in,
  input  logic fp_n,
  output logic bnd
);

  logic c4_q;
  logic fp_last;
  logic c4_fall;

  assign c4_fall = c4_q & ~c4_in;
  // A boundary is a high-to-low transition of the pulse seen at successive slow falls
  assign bnd     = c4_fall & ~fp_n & fp_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      c4_q    <= 1'b0;
      fp_last <= 1'b1;
    end else begin
      c4_q <= c4_in;
      if (c4_fall) begin
        fp_last <= fp_n;
      end
    end
  end

  // R3
  bnd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bnd) |-> (!c4_in && $past(c4_in)));

  // R6
  single_bnd_chk: assert property (@(posedge clk) disable iff (rst)
    bnd |=> !bnd);

endmodule

// File: rtl/tfg_master_cnt.sv
module tfg_master_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd,
  input  tfg_pkg::dly_e    dly,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  import tfg_pkg::*;

  logic bnd_q;
  logic rst_req;

  always_ff @(posedge clk) begin
    if (rst) bnd_q <= 1'b0;
    else     bnd_q <= bnd;
  end

  assign rst_req = (dly == RST_LATE) ? bnd_q : bnd;
  assign cnt_nxt = rst_req ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bnd) && !$past(bnd, 2))
      |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  edge_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bnd) && ($past(dly) == RST_ON_EDGE)) |-> (cnt == '0));

  // R5
  late_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(bnd, 2) &&
     ($past(dly, 2) == RST_LATE) && ($past(dly) == RST_LATE)) |-> (cnt == '0));

endmodule

// File: rtl/tfg_cmfp_gen.sv
module tfg_cmfp_gen #(
  parameter int CNT_W      = 11,
  parameter int LEAD_NODLY = 71,
  parameter int LEAD_DLY   = 68
) (
  input  logic             clk,
  input  logic             rst,
  input  tfg_pkg::dly_e    dly,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             cmfp_n
);
  import tfg_pkg::*;

  localparam int FRAME_LEN = 2 ** CNT_W;
  // With a late reset the counter zero trails the boundary by one clock
  localparam logic [CNT_W-1:0] TGT_EDGE = CNT_W'(FRAME_LEN - LEAD_NODLY);
  localparam logic [CNT_W-1:0] TGT_LATE = CNT_W'(FRAME_LEN - LEAD_DLY - 1);

  logic [CNT_W-1:0] tgt;
  assign tgt = (dly == RST_LATE) ? TGT_LATE : TGT_EDGE;

  always_ff @(posedge clk) begin
    if (rst) cmfp_n <= 1'b1;
    else     cmfp_n <= (cnt_nxt != tgt);
  end

  // R7
  cmfp_width_chk: assert property (@(posedge clk) disable iff (rst)
    !cmfp_n |=> cmfp_n);

  // R8
  cmfp_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmfp_n && $stable(dly))
      |-> (cnt == ((dly == RST_LATE) ? TGT_LATE : TGT_EDGE)));

endmodule

// File: rtl/tfg_strobe_gen.sv
module tfg_strobe_gen #(
  parameter int CNT_W   = 11,
  parameter int FAST_SH = 2,
  parameter int SLOW_SH = 3,
  parameter int CH_LOG  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  tfg_pkg::rate_e     rate,
  input  logic [CNT_W-1:0]   cnt_nxt,
  output logic               bit_stb,
  output logic               chan_stb,
  output logic [CH_LOG-1:0]  bit_idx,
  output logic [CNT_W-FAST_SH-CH_LOG-1:0] chan_idx
);
  import tfg_pkg::*;

  localparam int CHW = CNT_W - FAST_SH - CH_LOG;

  logic              lane_bit  [2];
  logic              lane_chan [2];
  logic [CH_LOG-1:0] lane_bidx [2];
  logic [CHW-1:0]    lane_cidx [2];

  // Lane 0 serves the slow rate, lane 1 the fast rate
  for (genvar r = 0; r < 2; r++) begin : g_lane
    localparam int SH = (r == 1) ? FAST_SH : SLOW_SH;
    assign lane_bit[r]  = (cnt_nxt[SH-1:0] == '0);
    assign lane_chan[r] = (cnt_nxt[SH+CH_LOG-1:0] == '0);
    assign lane_bidx[r] = cnt_nxt[SH+CH_LOG-1:SH];
    assign lane_cidx[r] = CHW'(cnt_nxt >> (SH + CH_LOG));
  end

  logic sel;
  assign sel = (rate == RATE_4M);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_stb  <= 1'b0;
      chan_stb <= 1'b0;
      bit_idx  <= '0;
      chan_idx <= '0;
    end else begin
      bit_stb  <= sel ? lane_bit[1]  : lane_bit[0];
      chan_stb <= sel ? lane_chan[1] : lane_chan[0];
      bit_idx  <= sel ? lane_bidx[1] : lane_bidx[0];
      chan_idx <= sel ? lane_cidx[1] : lane_cidx[0];
    end
  end

  // R9
  chan_bit_align_chk: assert property (@(posedge clk) disable iff (rst)
    chan_stb |-> (bit_stb && (bit_idx == '0)));

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int CNT_W      = 11,
  parameter int LEAD_NODLY = 71,
  parameter int LEAD_DLY   = 68,
  parameter int FAST_SH    = 2,
  parameter int SLOW_SH    = 3,
  parameter int CH_LOG     = 3,
  localparam int CHW       = CNT_W - FAST_SH - CH_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c4_in,
  input  logic              fp_n,
  input  logic              dly_sel,
  input  logic              rate_sel,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              bit_stb,
  output logic              chan_stb,
  output logic [CH_LOG-1:0] bit_idx,
  output logic [CHW-1:0]    chan_idx,
  output logic              cmfp_n
);
  import tfg_pkg::*;

  logic             bnd;
  logic [CNT_W-1:0] cnt_nxt;
  dly_e             dly;
  rate_e            rate;

  assign dly  = dly_e'(dly_sel);
  assign rate = rate_e'(rate_sel);

  tfg_fp_sampler u_samp (
    .clk   (clk),
    .rst   (rst),
    .c4_in (c4_in),
    .fp_n  (fp_n),
    .bnd   (bnd)
  );

  tfg_master_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .bnd     (bnd),
    .dly     (dly),
    .cnt     (frame_cnt),
    .cnt_nxt (cnt_nxt)
  );

  tfg_cmfp_gen #(
    .CNT_W      (CNT_W),
    .LEAD_NODLY (LEAD_NODLY),
    .LEAD_DLY   (LEAD_DLY)
  ) u_cmfp (
    .clk     (clk),
    .rst     (rst),
    .dly     (dly),
    .cnt     (frame_cnt),
    .cnt_nxt (cnt_nxt),
    .cmfp_n  (cmfp_n)
  );

  tfg_strobe_gen #(
    .CNT_W   (CNT_W),
    .FAST_SH (FAST_SH),
    .SLOW_SH (SLOW_SH),
    .CH_LOG  (CH_LOG)
  ) u_stb (
    .clk      (clk),
    .rst      (rst),
    .rate     (rate),
    .cnt_nxt  (cnt_nxt),
    .bit_stb  (bit_stb),
    .chan_stb (chan_stb),
    .bit_idx  (bit_idx),
    .chan_idx (chan_idx)
  );

endmodule

// File: tb/tb_tdm_frame_timer.sv
module tb_tdm_frame_timer;

  localparam int CLK_PERIOD = 10;
  localparam int FLEN       = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c4_in = 1'b1;
  logic        fp_n = 1'b1;
  logic        dly_sel = 1'b0;
  logic        rate_sel = 1'b0;
  logic [10:0] frame_cnt;
  logic        bit_stb;
  logic        chan_stb;
  logic [2:0]  bit_idx;
  logic [5:0]  chan_idx;
  logic        cmfp_n;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_frame_timer dut (
    .clk       (clk),
    .rst       (rst),
    .c4_in     (c4_in),
    .fp_n      (fp_n),
    .dly_sel   (dly_sel),
    .rate_sel  (rate_sel),
    .frame_cnt (frame_cnt),
    .bit_stb   (bit_stb),
    .chan_stb  (chan_stb),
    .bit_idx   (bit_idx),
    .chan_idx  (chan_idx),
    .cmfp_n    (cmfp_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next falling master edge, then drive the slow clock and pulse
  task automatic step(input bit fp_lo);
    @(negedge clk);
    ph    = (ph + 1) % 4;
    c4_in = (ph < 2);
    fp_n  = !fp_lo;
  endtask

  // Leave the slow clock so that the next step produces its falling edge
  task automatic align();
    while (ph != 1) step(0);
  endtask

  task automatic do_reset(input bit d, input bit r);
    dly_sel  = d;
    rate_sel = r;
    rst      = 1'b1;
    repeat (3) step(0);
    // R1
    chk(frame_cnt == 0, "R1 cnt", int'(frame_cnt), 0);
    chk(cmfp_n == 1'b1, "R1 cmfp_n", int'(cmfp_n), 1);
    chk(bit_stb == 1'b0 && chan_stb == 1'b0, "R1 strobes",
        int'({bit_stb, chan_stb}), 0);
    chk(bit_idx == 0 && chan_idx == 0, "R1 idx", int'({bit_idx, chan_idx}), 0);
    rst = 1'b0;
  endtask

  task automatic t_free_run();
    int prev = 0;
    int errs = 0;
    int first_act = 0;
    int first_exp = 0;
    bit wrapped = 0;
    do_reset(0, 0);
    for (int i = 0; i < FLEN + 60; i++) begin
      step(0);
      if (int'(frame_cnt) != (prev + 1) % FLEN) begin
        if (errs == 0) begin
          first_act = int'(frame_cnt);
          first_exp = (prev + 1) % FLEN;
        end
        errs++;
      end
      if (prev == FLEN - 1 && frame_cnt == 0) wrapped = 1;
      prev = int'(frame_cnt);
    end
    // R2
    chk(errs == 0, "R2 increment", first_act, first_exp);
    chk(wrapped, "R2 wrap", int'(wrapped), 1);
  endtask

  task automatic t_edge_resync();
    do_reset(0, 0);
    repeat (300) step(0);
    align();
    step(1);
    step(1);
    // R4
    chk(frame_cnt == 0, "R4 zero at boundary", int'(frame_cnt), 0);
    step(1);
    chk(frame_cnt == 1, "R4 count after", int'(frame_cnt), 1);
    repeat (20) step(0);
  endtask

  task automatic t_held_low();
    do_reset(0, 0);
    repeat (200) step(0);
    align();
    step(1);
    step(1);
    chk(frame_cnt == 0, "R6 first resync", int'(frame_cnt), 0);
    repeat (10) step(1);
    // R6: two more slow falls with the pulse still low
    chk(frame_cnt == 10, "R6 held low once", int'(frame_cnt), 10);
    repeat (8) step(0);
    chk(frame_cnt == 18, "R6 after release", int'(frame_cnt), 18);
  endtask

  task automatic t_off_edge();
    int pre;
    do_reset(0, 0);
    repeat (150) step(0);
    align();
    step(0);
    step(0);
    pre = int'(frame_cnt);
    step(1);
    step(1);
    step(0);
    step(0);
    // R3: pulse gone before the slow falling edge
    chk(int'(frame_cnt) == (pre + 4) % FLEN, "R3 off-edge ignored",
        int'(frame_cnt), (pre + 4) % FLEN);
  endtask

  task automatic t_late_resync();
    int pre;
    do_reset(1, 0);
    repeat (300) step(0);
    align();
    step(1);
    pre = int'(frame_cnt);
    step(1);
    // R5
    chk(int'(frame_cnt) == (pre + 1) % FLEN, "R5 no reset on edge",
        int'(frame_cnt), (pre + 1) % FLEN);
    step(0);
    chk(frame_cnt == 0, "R5 zero one clock later", int'(frame_cnt), 0);
    step(0);
    chk(frame_cnt == 1, "R5 count after", int'(frame_cnt), 1);
  endtask

  task automatic t_cmfp(input bit d);
    int n = 0;
    int m = 1;
    int tgt = d ? 1979 : 1977;
    int lead = d ? 69 : 71;
    string rq = d ? "R8" : "R7";
    do_reset(d, 0);
    repeat (100) step(0);
    align();
    step(1);
    step(1);
    if (d) step(0);
    chk(frame_cnt == 0, {rq, " resync"}, int'(frame_cnt), 0);
    while (cmfp_n && n < 3000) begin
      step(0);
      n++;
    end
    chk(int'(frame_cnt) == tgt, {rq, " pulse count"}, int'(frame_cnt), tgt);
    chk(n == tgt, {rq, " clocks from zero to pulse"}, n, tgt);
    step(0);
    chk(cmfp_n == 1'b1, {rq, " pulse width"}, int'(cmfp_n), 1);
    while (frame_cnt != 0 && m < 3000) begin
      step(0);
      m++;
    end
    chk(m == lead, {rq, " lead to counter zero"}, m, lead);
  endtask

  task automatic t_strobes(input bit r);
    int sh = r ? 2 : 3;
    int errs = 0;
    int c;
    int ebit;
    int echan;
    int ebi;
    int eci;
    int first_act = 0;
    int first_exp = 0;
    string rq = r ? "R10" : "R9";
    do_reset(0, r);
    for (int i = 0; i < FLEN + 100; i++) begin
      step(0);
      c     = int'(frame_cnt);
      ebit  = (c % (1 << sh)) == 0;
      echan = (c % (1 << (sh + 3))) == 0;
      ebi   = (c >> sh) % 8;
      eci   = c >> (sh + 3);
      if (int'(bit_stb) != ebit || int'(chan_stb) != echan ||
          int'(bit_idx) != ebi || int'(chan_idx) != eci) begin
        if (errs == 0) begin
          first_act = int'({bit_stb, chan_stb, bit_idx, chan_idx});
          first_exp = (ebit << 11) | (echan << 10) | (ebi << 6) | eci;
        end
        errs++;
      end
    end
    chk(errs == 0, {rq, " strobes and indices"}, first_act, first_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_free_run();
    t_edge_resync();
    t_held_low();
    t_off_edge();
    t_late_resync();
    t_cmfp(0);
    t_cmfp(1);
    t_strobes(0);
    t_strobes(1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule